// File: doc/BRIEF.md
# Aligned DMA Transfer Size Sequencer

This block turns one DMA request into the sequence of bus cycles needed to move it. A request carries a 32-bit start address, a 32-bit byte count, a data width (16, 32 or 64 bits) and a block-transfer enable. While the current address is misaligned, or too few bytes remain for a full-width cycle, the block issues narrow 1-byte and 2-byte cycles. In between it issues cycles of the programmed width. Any length from 1 byte up to 4 GB minus one can be described.

Each cycle is offered to a downstream cycle engine over a valid/ready handshake. The cycle carries an address, a size code and a burst-break flag. The flag tells the engine to end the current block transfer after this cycle and to open a new one. Breaks fall on 256-byte boundaries for 16-bit and 32-bit block transfers and on 2 KB boundaries for 64-bit block transfers. An address-space code and an address-modifier code are captured with the request and repeated on every cycle. Data movement, the FIFO and bus signalling belong to other blocks.

Top module: `dma_size_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `cyc_valid` and `done` are all 0.
- R2: A `start` pulse while idle with a non-zero count loads the request. From the next cycle `busy` and `cyc_valid` are 1 and `cyc_addr` equals `start_addr`.
- R3: Each cycle's size is the largest of 8, 4, 2 or 1 bytes that meets three conditions: it divides the current address, it does not exceed the remaining count, and it does not exceed the width. `cyc_size` is encoded 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes.
- R4: The width code `width_sel` is 0=16 bits, 1=32 bits, 2=64 bits, with 3 treated as 16 bits. No cycle exceeds 2, 4 or 8 bytes respectively.
- R5: No cycle exceeds the remaining count, and the sizes of all cycles of a request add up to its byte count.
- R6: While `cyc_valid` is 1 and `cyc_ready` is 0, the offered address, size and flag hold unchanged.
- R7: After an accepted cycle, the next offered address is the previous address plus the previous size, modulo 2^32.
- R8: In the cycle after the final cycle is accepted, `done` is 1 for one cycle, while `busy` and `cyc_valid` are 0.
- R9: A `start` with a byte count of 0 issues no cycle and raises `done` for one cycle in the next cycle.
- R10: With `blk_en` at 1, `cyc_brk` is 1 exactly when the cycle ends on a boundary and bytes remain after it. The boundary is 256 bytes for widths 0, 1 and 3, and 2048 bytes for width 2. With `blk_en` at 0, `cyc_brk` is always 0.
- R11: `cyc_aspace` and `cyc_am` repeat the `aspace` and `am_code` values captured at `start` on every cycle of the request.
- R12: A `start` while busy is ignored, and the running request continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request load pulse, honoured only while idle |
| start_addr | input | 32 | First byte address |
| byte_cnt | input | 32 | Number of bytes to move |
| width_sel | input | 2 | Data width code |
| blk_en | input | 1 | Block-transfer mode enable |
| aspace | input | 2 | Address-space code, captured at start |
| am_code | input | 6 | Address-modifier code, captured at start |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| cyc_valid | output | 1 | A cycle is offered |
| cyc_ready | input | 1 | Engine accepts the offered cycle |
| cyc_addr | output | 32 | Cycle address |
| cyc_size | output | 2 | Cycle size code |
| cyc_brk | output | 1 | End the block transfer after this cycle |
| cyc_aspace | output | 2 | Address-space code for the cycle |
| cyc_am | output | 6 | Address-modifier code for the cycle |

## Verification
The first cycle of a request is offered one clock after the `start` edge. Every later cycle appears one clock after the edge that accepted its predecessor. `done` follows one clock after the final acceptance, or one clock after a zero-count start. The bench drives inputs on falling edges and samples one falling edge after each rising edge. It keeps its own address and remaining-count model, which it advances only when it drove `cyc_ready` high across that edge, so each comparison lines up with the register update that produced it. Random ready stalls exercise the hold behaviour.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    WID_16  = 2'd0,
    WID_32  = 2'd1,
    WID_64  = 2'd2,
    WID_RSV = 2'd3
  } width_e;

  // largest size code allowed by a width code
  function automatic logic [1:0] width_cap(input width_e w);
    case (w)
      WID_32:  width_cap = 2'd2;
      WID_64:  width_cap = 2'd3;
      default: width_cap = 2'd1;
    endcase
  endfunction

  // size code from low address bits, remaining-count thresholds and the cap
  function automatic logic [1:0] pick_code(input logic [2:0] lo, input logic ge2,
                                           input logic ge4, input logic ge8,
                                           input logic [1:0] cap);
    if (lo[0] || !ge2)                      pick_code = 2'd0;
    else if (lo[1] || !ge4 || cap == 2'd1)  pick_code = 2'd1;
    else if (lo[2] || !ge8 || cap == 2'd2)  pick_code = 2'd2;
    else                                    pick_code = 2'd3;
  endfunction

endpackage

// File: rtl/size_pick.sv
module size_pick
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  rem,
  input  width_e            wsel,
  output logic [1:0]        code
);
  logic ge2, ge4, ge8;
  assign ge2 = rem >= CNT_W'(2);
  assign ge4 = rem >= CNT_W'(4);
  assign ge8 = rem >= CNT_W'(8);
  assign code = pick_code(addr[2:0], ge2, ge4, ge8, width_cap(wsel));
endmodule

// File: rtl/burst_brk.sv
module burst_brk
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SHORT_LOG = 8,
  parameter int LONG_LOG  = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        code,
  input  logic              more,
  input  width_e            wsel,
  input  logic              blk,
  output logic              brk
);
  localparam logic [ADDR_W-1:0] SHORT_MASK = (ADDR_W'(1) << SHORT_LOG) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] LONG_MASK  = (ADDR_W'(1) << LONG_LOG) - ADDR_W'(1);

  logic [ADDR_W-1:0] end_addr, mask;
  assign end_addr = addr + (ADDR_W'(1) << code);
  assign mask     = (wsel == WID_64) ? LONG_MASK : SHORT_MASK;
  assign brk      = blk && more && ((end_addr & mask) == '0);
endmodule

// File: rtl/dma_size_seq.sv
module dma_size_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 32,
  parameter int SHORT_LOG = 8,
  parameter int LONG_LOG  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [1:0]        width_sel,
  input  logic              blk_en,
  input  logic [1:0]        aspace,
  input  logic [5:0]        am_code,
  output logic              busy,
  output logic              done,
  output logic              cyc_valid,
  input  logic              cyc_ready,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [1:0]        cyc_size,
  output logic              cyc_brk,
  output logic [1:0]        cyc_aspace,
  output logic [5:0]        cyc_am
);
  logic              busy_q, done_q, blk_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q;
  width_e            wsel_q;
  logic [1:0]        as_q;
  logic [5:0]        am_q;

  logic [1:0]        code;
  logic [CNT_W-1:0]  step, rem_next;
  logic              accept, more, last_acc, load;

  size_pick #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_size (
    .addr(addr_q), .rem(rem_q), .wsel(wsel_q), .code(code)
  );

  assign step     = CNT_W'(1) << code;
  assign rem_next = rem_q - step;
  assign more     = rem_next != '0;
  assign accept   = busy_q && cyc_ready;
  assign last_acc = accept && !more;
  assign load     = start && !busy_q;

  burst_brk #(.ADDR_W(ADDR_W), .SHORT_LOG(SHORT_LOG), .LONG_LOG(LONG_LOG)) u_brk (
    .addr(addr_q), .code(code), .more(more), .wsel(wsel_q), .blk(blk_q), .brk(cyc_brk)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      blk_q  <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
      wsel_q <= WID_16;
      as_q   <= '0;
      am_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        addr_q <= start_addr;
        rem_q  <= byte_cnt;
        wsel_q <= width_e'(width_sel);
        blk_q  <= blk_en;
        as_q   <= aspace;
        am_q   <= am_code;
        busy_q <= byte_cnt != '0;
        done_q <= byte_cnt == '0;
      end else if (accept) begin
        addr_q <= addr_q + ADDR_W'(step);
        rem_q  <= rem_next;
        if (last_acc) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign cyc_valid  = busy_q;
  assign cyc_addr   = addr_q;
  assign cyc_size   = code;
  assign cyc_aspace = as_q;
  assign cyc_am     = am_q;

  // R3
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> ((cyc_addr & ((ADDR_W'(1) << cyc_size) - ADDR_W'(1))) == '0));
  // R4
  width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> (cyc_size <= 2'd1 || (cyc_size == 2'd2 && wsel_q != WID_16 && wsel_q != WID_RSV)
                   || (cyc_size == 2'd3 && wsel_q == WID_64)));
  // R5
  tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> (rem_q >= step));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && !cyc_ready |=> cyc_valid && $stable(cyc_addr) && $stable(cyc_size) && $stable(cyc_brk));
  // R8
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cyc_valid);
  // R10
  brk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && !blk_q |-> !cyc_brk);
endmodule

// File: tb/dma_size_seq_tb.sv
module dma_size_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, blk_en = 1'b0, cyc_ready = 1'b0;
  logic [31:0] start_addr = '0, byte_cnt = '0;
  logic [1:0] width_sel = '0, aspace = '0;
  logic [5:0] am_code = '0;
  logic busy, done, cyc_valid, cyc_brk;
  logic [31:0] cyc_addr;
  logic [1:0] cyc_size, cyc_aspace;
  logic [5:0] cyc_am;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_size_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .byte_cnt(byte_cnt),
    .width_sel(width_sel), .blk_en(blk_en), .aspace(aspace), .am_code(am_code),
    .busy(busy), .done(done), .cyc_valid(cyc_valid), .cyc_ready(cyc_ready),
    .cyc_addr(cyc_addr), .cyc_size(cyc_size), .cyc_brk(cyc_brk),
    .cyc_aspace(cyc_aspace), .cyc_am(cyc_am)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int width_bytes(input logic [1:0] w);
    if (w == 2'd1) return 4;
    if (w == 2'd2) return 8;
    return 2;
  endfunction

  // largest power of two that fits address, remainder and width
  function automatic int exp_bytes(input logic [31:0] a, input longint rem, input logic [1:0] w);
    for (int n = 8; n >= 1; n = n / 2)
      if (n <= width_bytes(w) && (a % n) == 0 && n <= rem) return n;
    return 1;
  endfunction

  function automatic int code_of(input int n);
    return (n == 8) ? 3 : (n == 4) ? 2 : (n == 2) ? 1 : 0;
  endfunction

  task automatic run_req(input logic [31:0] a, input logic [31:0] cnt, input logic [1:0] w,
                         input logic b, input logic [1:0] asp, input logic [5:0] am,
                         input bit stall, input bit poke);
    logic [31:0] ea;
    longint rem, total;
    int n, bound;
    bit rdy;
    ea = a; rem = cnt; total = 0;
    bound = (w == 2'd2) ? 2048 : 256;
    @(negedge clk);
    start = 1; start_addr = a; byte_cnt = cnt; width_sel = w; blk_en = b; aspace = asp; am_code = am;
    @(negedge clk);
    start = 0;
    if (cnt == 0) begin
      chk("R9 done", done, 1); chk("R9 valid", cyc_valid, 0);
      @(negedge clk);
      chk("R9 done drop", done, 0); chk("R9 busy", busy, 0);
      return;
    end
    chk("R2 busy", busy, 1); chk("R2 valid", cyc_valid, 1); chk("R2 addr", cyc_addr, a);
    if (poke) begin
      start = 1; start_addr = 32'h1234_5670; byte_cnt = 32'd5; aspace = ~asp;
    end
    while (rem > 0) begin
      n = exp_bytes(ea, rem, w);
      chk("R7 addr", cyc_addr, ea);
      chk("R3 R4 R5 size", cyc_size, code_of(n));
      chk("R10 brk", cyc_brk, (b && rem > n && ((ea + n) % bound) == 0) ? 1 : 0);
      chk("R11 aspace", cyc_aspace, asp); chk("R11 am", cyc_am, am);
      chk("R6 valid", cyc_valid, 1);
      rdy = stall ? ($urandom % 3 != 0) : 1'b1;
      cyc_ready = rdy;
      @(negedge clk);
      if (poke) begin start = 0; poke = 0; end
      cyc_ready = 0;
      if (rdy) begin ea = ea + n; rem = rem - n; total = total + n; end
    end
    chk("R5 total", total, cnt);
    chk("R8 done", done, 1); chk("R8 valid", cyc_valid, 0); chk("R8 busy", busy, 0);
    @(negedge clk);
    chk("R8 pulse", done, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 valid", cyc_valid, 0); chk("R1 done", done, 0);
    rst_n = 1;
    run_req(32'h0000_0003, 32'd13, 2'd1, 1'b0, 2'd1, 6'h0D, 1'b0, 1'b0);
    run_req(32'h0000_0001, 32'd20, 2'd0, 1'b0, 2'd0, 6'h29, 1'b1, 1'b0);
    run_req(32'h0000_07F5, 32'd40, 2'd2, 1'b1, 2'd2, 6'h0F, 1'b1, 1'b0);
    run_req(32'h0000_00F2, 32'd30, 2'd1, 1'b1, 2'd2, 6'h0B, 1'b0, 1'b0);
    run_req(32'h0000_01F8, 32'd24, 2'd0, 1'b1, 2'd1, 6'h3B, 1'b0, 1'b0);
    run_req(32'hFFFF_FFFC, 32'd9, 2'd3, 1'b1, 2'd3, 6'h3F, 1'b0, 1'b0);
    run_req(32'h0000_0010, 32'd0, 2'd2, 1'b1, 2'd0, 6'h00, 1'b0, 1'b0);
    run_req(32'h0000_0100, 32'd1, 2'd2, 1'b0, 2'd1, 6'h01, 1'b0, 1'b0);
    // R12 start pulse during busy must change nothing
    run_req(32'h0000_0406, 32'd21, 2'd2, 1'b0, 2'd1, 6'h2A, 1'b0, 1'b1);
    for (int i = 0; i < 40; i++)
      run_req($urandom, $urandom % 300, 2'($urandom), 1'($urandom), 2'($urandom),
              6'($urandom), 1'b1, 1'b0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule